// File: doc/BRIEF.md
# Single-Slope Fast PWM Timer

This block is a 16-bit up-counting timer that drives two pulse-width-modulated outputs, channel A and channel B. On each enabled timer tick the counter climbs from zero to a period limit and then drops back to zero on the following tick. The period limit comes from the waveform-mode code. It can be one of three fixed limits (8, 9 or 10 bits wide), the value of a period register, or the active channel A compare value.

Each channel compares the counter against its own compare value. Compare values are written into a holding register and are copied into the active register only at the period limit, so a new duty cycle always starts on a period boundary. A per-channel output mode selects a non-inverted waveform, an inverted waveform, or a pin held low. Four sticky flags report the period limit, each compare match, and the limit being reached while the period register defines it. Software clears a flag by writing 1 to its bit in the flag-clear register.

Top module: `fpwm_timer`

## Requirements
- R1: On each cycle with `tick` high, the counter increments by one, or becomes 0 if it equals the period limit (TOP). The period is TOP+1 ticks. On a cycle with `tick` low, the counter holds its value.
- R2: Mode code 5 gives TOP=0x00FF, code 6 gives TOP=0x01FF and code 7 gives TOP=0x03FF.
- R3: Mode code 14 takes TOP from the period register, and code 15 takes TOP from the active channel A compare value. The smallest legal register-defined TOP is 3. Any other mode code gives TOP=0xFFFF.
- R4: In output mode 2 (non-inverted), the pin is high while the counter is in 0..C, where C is the active compare value, and low for the rest of the period. The pin therefore stays high for min(C,TOP)+1 ticks of each period. When C is at or above TOP, the pin is high for the whole period.
- R5: Output mode 3 gives the complement of mode 2. In output modes 0 and 1, the pin stays low.
- R6: A written compare value goes into a holding register. It is copied to the active compare value only on the tick where the counter equals TOP, so the period that is running when the write happens keeps the old duty.
- R7: The overflow flag is set on the tick where the counter equals TOP. In mode 14 the capture flag is set on that same tick, and in mode 15 the channel A compare flag is set on that same tick. All flags become visible together with the counter returning to 0.
- R8: A channel's compare flag is set on a tick where the counter equals that channel's active compare value. If the compare value is above TOP, the flag is never set.
- R9: Flags are sticky. Writing 1 to a flag's bit in the flag-clear register clears it. A set event in the same cycle overrides the clear.
- R10: Register map, selected by `wr_addr`:
  - Address 0 is control: bits [3:0] hold the mode code, bits [5:4] the channel A output mode and bits [7:6] the channel B output mode.
  - Address 1 is the channel A compare holding register.
  - Address 2 is the channel B compare holding register.
  - Address 3 is the period register.
  - Address 4 is flag-clear: bit 0 clears overflow, bit 1 clears compare A, bit 2 clears compare B and bit 3 clears capture.
  - After reset, the counter, all registers, the flags and both pins are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timer clock enable; the counter advances only when high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address for the write |
| wr_data | input | 16 | Register write data |
| cnt_o | output | 16 | Current counter value |
| pwm_a | output | 1 | Channel A waveform pin |
| pwm_b | output | 1 | Channel B waveform pin |
| flag_ovf | output | 1 | Sticky flag: counter reached TOP |
| flag_cmpa | output | 1 | Sticky flag: channel A compare match |
| flag_cmpb | output | 1 | Sticky flag: channel B compare match |
| flag_cap | output | 1 | Sticky flag: TOP reached while the period register defines TOP |

## Verification
Each of the five period sources is run with its own compare values, and the measured period length and high-tick count on both pins are compared with the expected values. These runs separate the fixed limits from the register-defined limits and the non-inverted modes from the inverted modes. The compare settings include 0, values inside the period, a value equal to TOP and a value above TOP, which exposes off-by-one errors in the match and wrap priority. A compare write in the middle of a period tells double-buffered loading apart from immediate loading. Flag clears are timed to land on an ordinary cycle, just before TOP and exactly on TOP, which checks both the same-cycle flag pairing and the rule that a set overrides a clear.

// File: rtl/fpwm_pkg.sv
package fpwm_pkg;
  typedef enum logic [1:0] {
    OUT_OFF0   = 2'd0,
    OUT_OFF1   = 2'd1,
    OUT_NONINV = 2'd2,
    OUT_INV    = 2'd3
  } out_mode_e;

  localparam logic [3:0] MODE_FIX8  = 4'd5;
  localparam logic [3:0] MODE_FIX9  = 4'd6;
  localparam logic [3:0] MODE_FIX10 = 4'd7;
  localparam logic [3:0] MODE_PERREG = 4'd14;
  localparam logic [3:0] MODE_CMPA  = 4'd15;

  localparam logic [2:0] ADR_CTRL = 3'd0;
  localparam logic [2:0] ADR_CMPA = 3'd1;
  localparam logic [2:0] ADR_CMPB = 3'd2;
  localparam logic [2:0] ADR_PER  = 3'd3;
  localparam logic [2:0] ADR_FCLR = 3'd4;

  localparam int NFLAG = 4;
  localparam int FL_OVF  = 0;
  localparam int FL_CMPA = 1;
  localparam int FL_CMPB = 2;
  localparam int FL_CAP  = 3;
endpackage

// File: rtl/fpwm_regs.sv
module fpwm_regs #(
  parameter int W  = 16,
  parameter int NCH = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [2:0]                wr_addr,
  input  logic [W-1:0]              wr_data,
  input  logic                      load,
  output logic [3:0]                mode,
  output logic [NCH-1:0][1:0]       omode,
  output logic [W-1:0]              per_val,
  output logic [NCH-1:0][W-1:0]     cmp_act,
  output logic [fpwm_pkg::NFLAG-1:0] clr
);
  import fpwm_pkg::*;

  logic [NCH-1:0][W-1:0] cmp_hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode    <= '0;
      omode   <= '0;
      per_val <= '0;
    end else if (wr_en) begin
      if (wr_addr == ADR_CTRL) begin
        mode <= wr_data[3:0];
        for (int c = 0; c < NCH; c++) omode[c] <= wr_data[4+2*c +: 2];
      end
      if (wr_addr == ADR_PER) per_val <= wr_data;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_buf
    always_ff @(posedge clk) begin
      if (rst) begin
        cmp_hold[c] <= '0;
        cmp_act[c]  <= '0;
      end else begin
        if (wr_en && wr_addr == ADR_CMPA + 3'(c)) cmp_hold[c] <= wr_data;
        if (load) cmp_act[c] <= cmp_hold[c];
      end
    end
  end

  assign clr = (wr_en && wr_addr == ADR_FCLR) ? wr_data[NFLAG-1:0] : '0;
endmodule

// File: rtl/fpwm_counter.sv
module fpwm_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic [3:0]   mode,
  input  logic [W-1:0] per_val,
  input  logic [W-1:0] cmpa_act,
  output logic [W-1:0] cnt,
  output logic [W-1:0] top,
  output logic         at_top
);
  import fpwm_pkg::*;

  localparam logic [W-1:0] TOP8  = W'((1 << 8) - 1);
  localparam logic [W-1:0] TOP9  = W'((1 << 9) - 1);
  localparam logic [W-1:0] TOP10 = W'((1 << 10) - 1);

  always_comb begin
    case (mode)
      MODE_FIX8:   top = TOP8;
      MODE_FIX9:   top = TOP9;
      MODE_FIX10:  top = TOP10;
      MODE_PERREG: top = per_val;
      MODE_CMPA:   top = cmpa_act;
      default:     top = '1;
    endcase
  end

  assign at_top = tick && (cnt == top);

  always_ff @(posedge clk) begin
    if (rst)         cnt <= '0;
    else if (at_top) cnt <= '0;
    else if (tick)   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/fpwm_channel.sv
module fpwm_channel #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         at_top,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] cmp,
  input  logic [1:0]   omode,
  output logic         match,
  output logic         pin
);
  import fpwm_pkg::*;

  logic raw_q, raw_d, pin_d;

  assign match = tick && (cnt == cmp);

  always_comb begin
    raw_d = raw_q;
    if (at_top)     raw_d = 1'b1;
    else if (match) raw_d = 1'b0;
    case (out_mode_e'(omode))
      OUT_NONINV: pin_d = raw_d;
      OUT_INV:    pin_d = ~raw_d;
      default:    pin_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      raw_q <= 1'b0;
      pin   <= 1'b0;
    end else begin
      raw_q <= raw_d;
      pin   <= pin_d;
    end
  end
endmodule

// File: rtl/fpwm_flags.sv
module fpwm_flags #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flags
);
  always_ff @(posedge clk) begin
    if (rst) flags <= '0;
    else     flags <= set | (flags & ~clr);
  end
endmodule

// File: rtl/fpwm_timer.sv
module fpwm_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         wr_en,
  input  logic [2:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] cnt_o,
  output logic         pwm_a,
  output logic         pwm_b,
  output logic         flag_ovf,
  output logic         flag_cmpa,
  output logic         flag_cmpb,
  output logic         flag_cap
);
  import fpwm_pkg::*;

  localparam int NCH = 2;

  logic [3:0]            mode;
  logic [NCH-1:0][1:0]   omode;
  logic [W-1:0]          per_val;
  logic [NCH-1:0][W-1:0] cmp_act;
  logic [NFLAG-1:0]      clr, set, flags;
  logic [W-1:0]          top_w;
  logic                  at_top;
  logic [NCH-1:0]        match, pins;

  fpwm_regs #(.W(W), .NCH(NCH)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .load(at_top), .mode(mode), .omode(omode), .per_val(per_val),
    .cmp_act(cmp_act), .clr(clr)
  );

  fpwm_counter #(.W(W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .mode(mode), .per_val(per_val),
    .cmpa_act(cmp_act[0]), .cnt(cnt_o), .top(top_w), .at_top(at_top)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    fpwm_channel #(.W(W)) u_ch (
      .clk(clk), .rst(rst), .tick(tick), .at_top(at_top), .cnt(cnt_o),
      .cmp(cmp_act[c]), .omode(omode[c]), .match(match[c]), .pin(pins[c])
    );
  end

  always_comb begin
    set          = '0;
    set[FL_OVF]  = at_top;
    set[FL_CMPA] = match[0];
    set[FL_CMPB] = match[1];
    set[FL_CAP]  = at_top && (mode == MODE_PERREG);
  end

  fpwm_flags #(.N(NFLAG)) u_flags (
    .clk(clk), .rst(rst), .set(set), .clr(clr), .flags(flags)
  );

  assign pwm_a     = pins[0];
  assign pwm_b     = pins[1];
  assign flag_ovf  = flags[FL_OVF];
  assign flag_cmpa = flags[FL_CMPA];
  assign flag_cmpb = flags[FL_CMPB];
  assign flag_cap  = flags[FL_CAP];
endmodule

// File: rtl/fpwm_timer_chk.sv
module fpwm_timer_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         tick,
  input logic [W-1:0] cnt_o,
  input logic [W-1:0] top_w,
  input logic [3:0]   mode,
  input logic [1:0]   omode_a,
  input logic [W-1:0] cmpa_act,
  input logic         pwm_a,
  input logic         flag_ovf,
  input logic         flag_cmpa,
  input logic         flag_cap
);
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
    (tick && cnt_o == top_w) |=> (cnt_o == '0)); // R1
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(cnt_o)); // R1
  AST_OVF_AT_TOP: assert property (@(posedge clk) disable iff (rst)
    (tick && cnt_o == top_w) |=> flag_ovf); // R7
  AST_CAP_WITH_OVF: assert property (@(posedge clk) disable iff (rst)
    (tick && cnt_o == top_w && mode == 4'd14) |=> (flag_cap && flag_ovf)); // R7
  AST_CMPA_MATCH: assert property (@(posedge clk) disable iff (rst)
    (tick && cnt_o == cmpa_act) |=> flag_cmpa); // R8
  AST_PIN_OFF: assert property (@(posedge clk) disable iff (rst)
    (omode_a < 2'd2) |=> !pwm_a); // R5
endmodule

bind fpwm_timer fpwm_timer_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .cnt_o(cnt_o), .top_w(top_w),
  .mode(mode), .omode_a(omode[0]), .cmpa_act(cmp_act[0]), .pwm_a(pwm_a),
  .flag_ovf(flag_ovf), .flag_cmpa(flag_cmpa), .flag_cap(flag_cap)
);

// File: tb/fpwm_timer_tb.sv
module fpwm_timer_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] cnt_o;
  logic        pwm_a, pwm_b, flag_ovf, flag_cmpa, flag_cmpb, flag_cap;
  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  fpwm_timer u_dut (
    .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cnt_o(cnt_o), .pwm_a(pwm_a), .pwm_b(pwm_b),
    .flag_ovf(flag_ovf), .flag_cmpa(flag_cmpa), .flag_cmpb(flag_cmpb),
    .flag_cap(flag_cap)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; tick = 1'b0; wr_en = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic setup(input logic [3:0] m, input logic [1:0] oa, input logic [1:0] ob,
                       input logic [15:0] ca, input logic [15:0] cb, input logic [15:0] per);
    do_reset();
    wr(3'd0, {8'd0, ob, oa, m});
    wr(3'd1, ca);
    wr(3'd2, cb);
    wr(3'd3, per);
    tick = 1'b1;
  endtask

  task automatic wait_zero();
    do @(negedge clk); while (cnt_o == 16'd0);
    do @(negedge clk); while (cnt_o != 16'd0);
  endtask

  task automatic wait_cnt(input logic [15:0] v);
    do @(negedge clk); while (cnt_o != v);
  endtask

  task automatic measure(input bit do_wr, input logic [2:0] a, input logic [15:0] d,
                         output int per, output int ha, output int hb);
    per = 0; ha = 0; hb = 0;
    do begin
      ha += int'(pwm_a);
      hb += int'(pwm_b);
      per++;
      if (do_wr && per == 3) begin wr_en = 1'b1; wr_addr = a; wr_data = d; end
      if (per == 4) wr_en = 1'b0;
      @(negedge clk);
    end while (cnt_o != 16'd0);
  endtask

  task automatic t_reset();
    do_reset();
    @(negedge clk);
    chk("R10 reset cnt", int'(cnt_o), 0);
    chk("R10 reset pins", int'({pwm_a, pwm_b}), 0);
    chk("R10 reset flags", int'({flag_ovf, flag_cmpa, flag_cmpb, flag_cap}), 0);
  endtask

  task automatic t_fix8();
    int p, ha, hb;
    logic [15:0] c0;
    setup(4'd5, 2'd2, 2'd3, 16'd10, 16'd100, 16'd0);
    wait_zero();
    measure(1'b1, 3'd1, 16'd50, p, ha, hb);
    chk("R2 mode5 period", p, 256);
    chk("R4 noninv high A=10", ha, 11);
    chk("R6 old duty kept in write period", ha, 11);
    chk("R5 inverted B=100", hb, 256 - 101);
    measure(1'b0, 3'd0, 16'd0, p, ha, hb);
    chk("R6 new duty after TOP", ha, 51);
    wait_cnt(16'd7);
    tick = 1'b0;
    c0 = cnt_o;
    repeat (5) @(negedge clk);
    chk("R1 hold when tick low", int'(cnt_o), int'(c0));
    tick = 1'b1;
  endtask

  task automatic t_fix9();
    int p, ha, hb;
    setup(4'd6, 2'd2, 2'd1, 16'd0, 16'd40, 16'd0);
    wait_zero();
    measure(1'b0, 3'd0, 16'd0, p, ha, hb);
    chk("R2 mode6 period", p, 512);
    chk("R4 compare 0 high one tick", ha, 1);
    chk("R5 mode1 pin low", hb, 0);
  endtask

  task automatic t_fix10();
    int p, ha, hb;
    setup(4'd7, 2'd3, 2'd2, 16'd1023, 16'd700, 16'd0);
    wait_zero();
    measure(1'b0, 3'd0, 16'd0, p, ha, hb);
    chk("R2 mode7 period", p, 1024);
    chk("R5 inverted compare=TOP low", ha, 0);
    chk("R4 noninv B=700", hb, 701);
  endtask

  task automatic t_flags();
    int p, ha, hb;
    setup(4'd5, 2'd2, 2'd0, 16'd300, 16'd100, 16'd0);
    wait_zero();
    measure(1'b0, 3'd0, 16'd0, p, ha, hb);
    chk("R4 compare above TOP high all period", ha, 256);
    wr(3'd4, 16'h000F);
    chk("R9 write-1 clears flags", int'({flag_ovf, flag_cmpa, flag_cmpb, flag_cap}), 0);
    wait_zero();
    chk("R7 overflow set at TOP", int'(flag_ovf), 1);
    chk("R8 compare B flag", int'(flag_cmpb), 1);
    chk("R8 compare A above TOP no flag", int'(flag_cmpa), 0);
    chk("R7 capture flag not in mode5", int'(flag_cap), 0);
    wait_cnt(16'd255);
    wr_en = 1'b1; wr_addr = 3'd4; wr_data = 16'h0001;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R9 set wins over clear", int'(flag_ovf), 1);
    wr(3'd4, 16'h0001);
    chk("R9 clear on quiet cycle", int'(flag_ovf), 0);
  endtask

  task automatic t_perreg();
    int p, ha, hb;
    setup(4'd14, 2'd0, 2'd2, 16'd0, 16'd1, 16'd3);
    wait_zero();
    measure(1'b0, 3'd0, 16'd0, p, ha, hb);
    chk("R3 mode14 minimum TOP period", p, 4);
    chk("R4 noninv B=1 at TOP=3", hb, 2);
    wait_cnt(16'd1);
    wr_en = 1'b1; wr_addr = 3'd4; wr_data = 16'h000F;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R7 ovf cleared before TOP", int'(flag_ovf), 0);
    chk("R7 cap cleared before TOP", int'(flag_cap), 0);
    wait_zero();
    chk("R7 cap set with ovf", int'({flag_cap, flag_ovf}), 3);
  endtask

  task automatic t_cmpa_top();
    int p, ha, hb;
    setup(4'd15, 2'd2, 2'd3, 16'd99, 16'd20, 16'd0);
    wait_zero();
    measure(1'b0, 3'd0, 16'd0, p, ha, hb);
    chk("R3 mode15 period from compare A", p, 100);
    chk("R4 compare equals TOP high all", ha, 100);
    chk("R5 inverted B=20", hb, 79);
    wait_cnt(16'd5);
    wr(3'd4, 16'h000F);
    wait_cnt(16'd99);
    chk("R7 cmpA and ovf clear before TOP", int'({flag_cmpa, flag_ovf}), 0);
    @(negedge clk);
    chk("R7 cmpA set with ovf", int'({flag_cmpa, flag_ovf}), 3);
  endtask

  task automatic t_freerun();
    setup(4'd0, 2'd0, 2'd0, 16'd0, 16'd0, 16'd0);
    wait_cnt(16'd2000);
    chk("R3 other mode passes 10-bit limit", int'(flag_ovf), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_fix8();
    t_fix9();
    t_fix10();
    t_flags();
    t_perreg();
    t_cmpa_top();
    t_freerun();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule